// File: doc/BRIEF.md
# Processor Status Word and Trap Qualifier

This block keeps the processor status word: four condition codes written by executing instructions, three enables for arithmetic exception trapping, and a single-step trace bit. Execution presents per-flag update strobes with new flag values, and raises exception event lines while an instruction runs. When the end-of-instruction strobe arrives, the block decides whether the finished instruction must trap. It reports the decision as a one-cycle trap request together with a numeric cause.

Some arithmetic exceptions trap only when their enable bit is set. Others trap no matter what the enables say. When the trace bit is set, every completed instruction traps. If several reasons to trap arise together, a fixed ranking chooses the single cause that is reported. Privileged software can overwrite the whole word through a write port.

Top module: `psw_trap_unit`

## Requirements
- R1: After reset, `psw` is zero, `trap_req` is 0 and `trap_cause` is 0.
- R2: Bit positions in `psw`: carry C=0, overflow V=1, zero Z=2, negative N=3, trace T=4, integer-overflow enable=5, floating-underflow enable=6, decimal-overflow enable=7. Bits 15:8 always read 0 and ignore written values.
- R3: Flag bit i (i=0..3, in the order C, V, Z, N) takes `cc_val[i]` on the next edge only when `cc_upd[i]` is 1. Flags whose strobe is 0 keep their value.
- R4: Integer overflow, floating underflow and decimal overflow cause a trap only when their enable bit (5, 6 and 7 respectively) is set. With the enable clear, the event raises no trap.
- R5: Divide-by-zero and floating overflow cause a trap whatever the enable bits hold.
- R6: When T (bit 4) is set, every end-of-instruction strobe produces a trap, with cause 6 if no arithmetic cause qualifies.
- R7: Cause codes are 1 integer overflow, 2 divide-by-zero, 3 floating overflow, 4 floating underflow, 5 decimal overflow, 6 trace. When several causes qualify, the one reported is chosen in this order: 2, 3, 4, 1, 5, 6.
- R8: Traps are judged only in a cycle with `eoi`=1. The judgement uses the word as it stood in that cycle, and `trap_req`/`trap_cause` show the result for the following cycle only. In every other cycle they read 0.
- R9: When `wr_en`=1, `psw[7:0]` takes `wr_data[7:0]` on the next edge, and any flag update in that same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cc_upd | input | 4 | Per-flag update strobes (C,V,Z,N) |
| cc_val | input | 4 | New flag values (C,V,Z,N) |
| ev_intovf | input | 1 | Integer overflow event |
| ev_divzero | input | 1 | Divide-by-zero event |
| ev_fltovf | input | 1 | Floating overflow event |
| ev_fltund | input | 1 | Floating underflow event |
| ev_decovf | input | 1 | Decimal overflow event |
| eoi | input | 1 | End-of-instruction strobe |
| wr_en | input | 1 | Privileged write enable |
| wr_data | input | 16 | Privileged write value |
| psw | output | 16 | Current status word |
| trap_req | output | 1 | Trap request, one cycle |
| trap_cause | output | 3 | Encoded trap cause |

## Verification
All three results are registered, so each one is due exactly one clock edge after the cycle that carries its stimulus. A status-word write or flag update shows in `psw` after the next edge. A trap decision made in an `eoi` cycle shows in `trap_req`/`trap_cause` after that same edge and is gone one edge later. The driver applies inputs on the falling edge and queues the expected word, request and cause. The monitor compares them shortly after the next rising edge, so each comparison falls in the single cycle in which its result is due.

// File: rtl/psw_trap_unit.sv
module psw_trap_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   cc_upd,
  input  logic [3:0]   cc_val,
  input  logic         ev_intovf,
  input  logic         ev_divzero,
  input  logic         ev_fltovf,
  input  logic         ev_fltund,
  input  logic         ev_decovf,
  input  logic         eoi,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] psw,
  output logic         trap_req,
  output logic [2:0]   trap_cause
);
  localparam int LOW = 8;
  localparam logic [2:0] C_NONE = 3'd0, C_IOV = 3'd1, C_DIV = 3'd2,
                         C_FOV = 3'd3, C_FUN = 3'd4, C_DOV = 3'd5,
                         C_TRC = 3'd6;

  logic [LOW-1:0] word;
  logic [3:0]     cc_next;
  logic [2:0]     cause_d;

  wire en_iv = word[5];
  wire en_fu = word[6];
  wire en_dv = word[7];
  wire trace = word[4];

  assign psw = {{(W-LOW){1'b0}}, word};

  for (genvar i = 0; i < 4; i++) begin : g_cc
    assign cc_next[i] = cc_upd[i] ? cc_val[i] : word[i];
  end

  always_comb begin
    if (ev_divzero)               cause_d = C_DIV;
    else if (ev_fltovf)           cause_d = C_FOV;
    else if (ev_fltund && en_fu)  cause_d = C_FUN;
    else if (ev_intovf && en_iv)  cause_d = C_IOV;
    else if (ev_decovf && en_dv)  cause_d = C_DOV;
    else if (trace)               cause_d = C_TRC;
    else                          cause_d = C_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word       <= '0;
      trap_req   <= 1'b0;
      trap_cause <= C_NONE;
    end else begin
      if (wr_en) word <= wr_data[LOW-1:0];
      else       word <= {word[LOW-1:4], cc_next};
      trap_req   <= eoi && (cause_d != C_NONE);
      trap_cause <= eoi ? cause_d : C_NONE;
    end
  end

  a_r9_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> psw[7:0] == $past(wr_data[7:0]));
  a_r3_carry_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !cc_upd[0]) |=> psw[0] == $past(psw[0]));
  a_r5_divzero_traps: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && ev_divzero) |=> (trap_req && trap_cause == C_DIV));
  a_r6_trace_traps: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && psw[4]) |=> trap_req);
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !eoi |=> (!trap_req && trap_cause == C_NONE));
  a_r4_iv_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && ev_intovf && !psw[5] && !psw[4] && !ev_divzero && !ev_fltovf
     && !ev_fltund && !ev_decovf) |=> !trap_req);
  a_r7_req_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req == (trap_cause != C_NONE));
endmodule

// File: tb/sim_psw_trap_unit.sv
module sim_psw_trap_unit;
  localparam int PER = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] cc_upd = '0, cc_val = '0;
  logic ev_intovf = 0, ev_divzero = 0, ev_fltovf = 0, ev_fltund = 0, ev_decovf = 0;
  logic eoi = 0, wr_en = 0;
  logic [15:0] wr_data = '0;
  logic [15:0] psw;
  logic trap_req;
  logic [2:0] trap_cause;

  int total = 0, bad = 0;
  bit done = 0;
  logic [19:0] exp_q[$];
  string tag_q[$];
  logic [7:0] m_word = '0;

  always #(PER/2) clk = ~clk;

  psw_trap_unit u0 (.clk, .rst_n, .cc_upd, .cc_val, .ev_intovf, .ev_divzero,
    .ev_fltovf, .ev_fltund, .ev_decovf, .eoi, .wr_en, .wr_data,
    .psw, .trap_req, .trap_cause);

  task automatic check(string tag, logic [19:0] got, logic [19:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got req=%0d cause=%0d psw=%h exp req=%0d cause=%0d psw=%h",
               tag, got[19], got[18:16], got[15:0], exp[19], exp[18:16], exp[15:0]);
    end
  endtask

  // driver: apply one cycle of stimulus and queue the expected result
  task automatic step(string tag, logic e, logic [4:0] ev, logic [3:0] up,
                      logic [3:0] val, logic w, logic [15:0] wd);
    logic [2:0] c;
    @(negedge clk);
    eoi = e; {ev_decovf, ev_fltund, ev_fltovf, ev_divzero, ev_intovf} = ev;
    cc_upd = up; cc_val = val; wr_en = w; wr_data = wd;
    if (ev[1]) c = 2;
    else if (ev[2]) c = 3;
    else if (ev[3] && m_word[6]) c = 4;
    else if (ev[0] && m_word[5]) c = 1;
    else if (ev[4] && m_word[7]) c = 5;
    else if (m_word[4]) c = 6;
    else c = 0;
    if (!e) c = 0;
    if (w) m_word = wd[7:0];
    else for (int i = 0; i < 4; i++) if (up[i]) m_word[i] = val[i];
    exp_q.push_back({c != 0, c, 8'h00, m_word});
    tag_q.push_back(tag);
  endtask

  // monitor
  initial forever begin
    @(posedge clk); #1;
    if (exp_q.size() > 0)
      check(tag_q.pop_front(), {trap_req, trap_cause, psw}, exp_q.pop_front());
  end

  initial begin
    #(PER * 20000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", {trap_req, trap_cause, psw}, 20'h0);
    rst_n = 1'b1;
    // R3 flag updates with masks
    step("R3 set N,C", 0, 5'b0, 4'b1001, 4'b1111, 0, 0);
    step("R3 mask keeps", 0, 5'b0, 4'b0110, 4'b0110, 0, 0);
    step("R3 clear C only", 0, 5'b0, 4'b0001, 4'b0000, 0, 0);
    // R2 high bits ignore writes
    step("R2 high bits zero", 0, 5'b0, 0, 0, 1, 16'hFF00);
    // R4 masked events, V still updated
    step("R4 iv off no trap", 1, 5'b00001, 4'b0010, 4'b0010, 0, 0);
    step("R4 fu,dv off no trap", 1, 5'b11000, 0, 0, 0, 0);
    step("R8 idle after trap", 0, 5'b0, 0, 0, 0, 0);
    // R5 unmaskable
    step("R5 divzero", 1, 5'b00010, 0, 0, 0, 0);
    step("R5 fltovf", 1, 5'b00100, 0, 0, 0, 0);
    step("R8 held one cycle", 0, 5'b0, 0, 0, 0, 0);
    step("R8 event without eoi", 0, 5'b00110, 0, 0, 0, 0);
    // R9 write beats flag update; enables from before the write
    step("R9 write wins", 1, 5'b00001, 4'b1111, 4'b1111, 1, 16'h00E0);
    step("R4 iv on", 1, 5'b00001, 0, 0, 0, 0);
    step("R4 fu on", 1, 5'b01000, 0, 0, 0, 0);
    step("R4 dv on", 1, 5'b10000, 0, 0, 0, 0);
    step("R7 fu before iv", 1, 5'b11001, 0, 0, 0, 0);
    step("R7 iv before dv", 1, 5'b10001, 0, 0, 0, 0);
    step("R7 div before fov", 1, 5'b11111, 0, 0, 0, 0);
    step("R7 fov before fu", 1, 5'b01100, 0, 0, 0, 0);
    // R6 trace
    step("R9 set trace", 0, 5'b0, 0, 0, 1, 16'h0010);
    step("R6 trace plain", 1, 5'b0, 4'b0100, 4'b0100, 0, 0);
    step("R6 trace again", 1, 5'b0, 0, 0, 0, 0);
    step("R7 arith before trace", 1, 5'b00100, 0, 0, 0, 0);
    step("R4 masked iv gives trace", 1, 5'b00001, 0, 0, 0, 0);
    step("R8 trace needs eoi", 0, 5'b0, 0, 0, 0, 0);
    step("R1 clear all", 0, 5'b0, 0, 0, 1, 16'h0000);
    step("R8 no cause no trap", 1, 5'b0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule